// File: doc/BRIEF.md
# Cascadable 8/16-bit pulse generator

Two 8-bit down counters, channel 0 and channel 1, each produce a rectangular pulse by alternating between a low phase and a high phase. Each phase length comes from its own reload register. When a counter is at zero and steps again, it records an underflow in a sticky flag. The flag can raise an interrupt request. The counter then reloads for the other phase.

A mode field selects how the two channels relate:
- two free-running independent 8-bit generators;
- an 8+8 arrangement, where each underflow of channel 0 is the count tick of channel 1;
- one 16-bit generator, formed by chaining both counters.

A small word-wide register port loads the reload values and the two channel control bytes. Byte enables let one channel's byte be written alone.

Top module: `pulse_pair_gen`

## Requirements
- R1: After reset, `pulse_out` and `irq` are 0. Register 0 (control word) reads 16'h8080: each control byte has bit 7 reading 1 and all other bits 0.
- R2: Assume the writing clock edge is E and the channel's reload values are L and H. The counter loads L on edge E+1 and starts decrementing from E+2. The output is low through E+L+1, high from E+L+2 through E+L+H+2, and low again from E+L+H+3.
- R3: With run (control bit 0) at 0, the channel's `pulse_out` is low. `pulse_oe` of a channel follows its output-enable bit (control bit 1).
- R4: In both 8-bit modes, a channel's underflow flag (control bit 3) becomes 1 on the edge where its counter leaves 0. This is the same edge where the output changes phase.
- R5: Writing 0 to the flag bit clears the flag. Writing 1 leaves it unchanged.
- R6: A read with `rd_rmw` high returns 1 in both flag bits, whatever their state.
- R7: `irq` of a channel is 1 exactly when its flag is 1 and its interrupt enable (control bit 2) is 1.
- R8: Mode field (channel-1 byte bits 5:4) value 2'b10 behaves as independent mode (2'b00). It sets the illegal-mode status, channel-0 byte bit 4.
- R9: In modes 2'b01 and 2'b11, if only one run bit is set, both channels stay stopped. The pair-error status, channel-0 byte bit 5, reads 1.
- R10: In mode 2'b11, the reload values are {channel 1, channel 0} in 16 bits. Only the 0x0000 step sets channel 1's flag; a wrap of the lower byte does not. Channel 0's output stays low and its flag is not set.
- R11: In mode 2'b01, channel 1 decrements only on channel 0 underflows.
- R12: Bit 6 of each control byte reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | 0 control word, 1 low-phase reloads, 2 high-phase reloads |
| wr_be | input | 2 | byte-lane enables: lane 0 is channel 0, lane 1 is channel 1 |
| wr_data | input | 2*CW | write data |
| rd_addr | input | 2 | read register select |
| rd_rmw | input | 1 | read belongs to a read-modify-write sequence |
| rd_data | output | 2*CW | read data, combinational |
| pulse_out | output | 2 | pulse per channel |
| pulse_oe | output | 2 | pulse output valid per channel |
| irq | output | 2 | interrupt request per channel |

## Verification
The bench builds the block with the default lane width `CW` = 8.

At this width, a 16-bit low-phase value of 0x0102 finishes in about 260 cycles. That run crosses a lower-byte wrap before the true 0x0000 underflow, so the test separates the two events.

Short 8-bit reload values of 0 to 5 place every phase edge, and the prescaled channel-1 edges, within a few cycles. This lets each predicted edge be checked cycle by cycle.

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [1:0]    wr_be,
  input  logic [2*CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  input  logic          rd_rmw,
  output logic [2*CW-1:0] rd_data,
  output logic [1:0]    pulse_out,
  output logic [1:0]    pulse_oe,
  output logic [1:0]    irq
);
  localparam int DW = 2 * CW;

  logic [1:0]    run, oe, ie, flag, ph, go_q;
  logic [1:0]    mode;
  logic [CW-1:0] lo [2];
  logic [CW-1:0] hi [2];
  logic [CW-1:0] cnt [2];

  wire indep    = ~mode[0];
  wire presc    = (mode == 2'b01);
  wire chain    = (mode == 2'b11);
  wire mode_bad = (mode == 2'b10);
  wire pair_err = ~indep & (run[0] ^ run[1]);
  wire wctrl    = wr_en & (wr_addr == 2'd0);

  wire [1:0] go    = indep ? run : {2{&run}};
  wire [1:0] start = go & ~go_q;

  logic [1:0]    tick, uf8, uf_set;
  logic [DW-1:0] cnt16;
  logic          uf16;

  always_comb begin
    tick[0] = go[0] & ~start[0];
    uf8[0]  = tick[0] & (cnt[0] == '0);
    tick[1] = go[1] & ~start[1] & (presc ? uf8[0] : 1'b1);
    uf8[1]  = tick[1] & (cnt[1] == '0);
    cnt16   = {cnt[1], cnt[0]};
    uf16    = go[1] & ~start[1] & (cnt16 == '0);
    uf_set  = chain ? {uf16, 1'b0} : uf8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt[0] <= '0;
      cnt[1] <= '0;
      ph     <= '0;
      go_q   <= '0;
    end else begin
      go_q <= go;
      if (chain) begin
        ph[0] <= 1'b0;
        if (!go[1]) ph[1] <= 1'b0;
        else if (start[1]) begin
          {cnt[1], cnt[0]} <= {lo[1], lo[0]};
          ph[1] <= 1'b0;
        end else if (uf16) begin
          ph[1] <= ~ph[1];
          {cnt[1], cnt[0]} <= ph[1] ? {lo[1], lo[0]} : {hi[1], hi[0]};
        end else
          {cnt[1], cnt[0]} <= cnt16 - 1'b1;
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (!go[i]) ph[i] <= 1'b0;
          else if (start[i]) begin
            cnt[i] <= lo[i];
            ph[i]  <= 1'b0;
          end else if (uf8[i]) begin
            ph[i]  <= ~ph[i];
            cnt[i] <= ph[i] ? lo[i] : hi[i];
          end else if (tick[i])
            cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      oe    <= '0;
      ie    <= '0;
      flag  <= '0;
      mode  <= '0;
      lo[0] <= '0;
      lo[1] <= '0;
      hi[0] <= '0;
      hi[1] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        flag[i] <= uf_set[i] | (flag[i] & ~(wctrl & wr_be[i] & ~wr_data[i*CW+3]));
        if (wr_en && wr_be[i]) begin
          if (wr_addr == 2'd0) begin
            run[i] <= wr_data[i*CW];
            oe[i]  <= wr_data[i*CW+1];
            ie[i]  <= wr_data[i*CW+2];
          end
          if (wr_addr == 2'd1) lo[i] <= wr_data[i*CW +: CW];
          if (wr_addr == 2'd2) hi[i] <= wr_data[i*CW +: CW];
        end
      end
      if (wctrl && wr_be[1]) mode <= wr_data[CW+5:CW+4];
    end
  end

  logic [DW-1:0] ctrl_rd;
  wire  [1:0]    flag_rd = flag | {2{rd_rmw}};

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[7:0]      = {1'b1, 1'b0, pair_err, mode_bad, flag_rd[0], ie[0], oe[0], run[0]};
    ctrl_rd[CW+7:CW]  = {1'b1, 1'b0, mode, flag_rd[1], ie[1], oe[1], run[1]};
    case (rd_addr)
      2'd0:    rd_data = ctrl_rd;
      2'd1:    rd_data = {lo[1], lo[0]};
      2'd2:    rd_data = {hi[1], hi[0]};
      default: rd_data = '0;
    endcase
  end

  assign pulse_out = go & ph & (chain ? 2'b10 : 2'b11);
  assign pulse_oe  = oe;
  assign irq       = flag & ie;
endmodule

module pulse_pair_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [1:0]    wr_be,
  input logic [2*CW-1:0] wr_data,
  input logic [1:0]    run,
  input logic [1:0]    ph,
  input logic [1:0]    flag,
  input logic [1:0]    mode,
  input logic          pair_err,
  input logic [1:0]    pulse_out
);
  p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run[0] |=> !pulse_out[0] || run[0]);

  p_uf_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> ph[0] != $past(ph[0]));

  p_w0c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag[0]) |-> $past(wr_en && wr_addr == 2'd0 && wr_be[0] && !wr_data[3]));

  p_pair_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> pulse_out == 2'b00);

  p_chain_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> !pulse_out[0]);
endmodule

bind pulse_pair_gen pulse_pair_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
  .wr_data(wr_data), .run(run), .ph(ph), .flag(flag), .mode(mode),
  .pair_err(pair_err), .pulse_out(pulse_out)
);

// File: tb/tb_pulse_pair_gen.sv
module tb_pulse_pair_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_rmw = 0;
  logic [1:0]  wr_addr = 0, wr_be = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic [1:0]  pulse_out, pulse_oe, irq;

  pulse_pair_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int at; int sel; int idx; logic val; string tag; } item_t;
  item_t q[$];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input int at, input int sel, input int idx, input logic val, input string tag);
    item_t it;
    it.at = at; it.sel = sel; it.idx = idx; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic g;
      it = q.pop_front();
      g = (it.sel == 0) ? pulse_out[it.idx] : (it.sel == 1) ? irq[it.idx] : pulse_oe[it.idx];
      if (it.at < cyc) chk({it.tag, " missed sample"}, 16'd0, 16'd1);
      else chk(it.tag, {15'd0, g}, {15'd0, it.val});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d, output int e);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    @(posedge clk);
    #1;
    e = cyc;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic m, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a; rd_rmw = m;
    #1;
    d = rd_data;
    rd_rmw = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, 0, d);
    chk("R1 control word after reset", d, 16'h8080);
    chk("R1 outputs after reset", {12'd0, pulse_out, irq}, 16'd0);

    // R2 R4 R7: independent channel 0, L=2 H=3
    wr(2'd1, 2'b11, 16'h0002, e);
    wr(2'd2, 2'b11, 16'h0003, e);
    wr(2'd0, 2'b11, 16'h8087, e);
    push(e+1, 0, 0, 0, "R2 low after load");
    push(e+3, 0, 0, 0, "R2 end of low phase");
    push(e+3, 1, 0, 0, "R7 no irq before underflow");
    push(e+4, 0, 0, 1, "R2 high phase starts");
    push(e+4, 1, 0, 1, "R4 R7 irq at underflow");
    push(e+7, 0, 0, 1, "R2 end of high phase");
    push(e+8, 0, 0, 0, "R2 back to low");
    drain();
    rd(2'd0, 0, d);
    chk("R4 flag set", {15'd0, d[3]}, 16'd1);
    chk("R3 oe follows bit", {14'd0, pulse_oe}, 16'd1);

    // R5 write 1 keeps, stop channel
    wr(2'd0, 2'b01, 16'h008E, e);
    push(e, 0, 0, 0, "R3 stopped output low");
    push(e+2, 0, 0, 0, "R3 stopped output stays low");
    drain();
    rd(2'd0, 0, d);
    chk("R5 write 1 keeps flag", {15'd0, d[3]}, 16'd1);
    wr(2'd0, 2'b01, 16'h008A, e);
    push(e, 1, 0, 0, "R7 irq off with enable 0");
    drain();
    rd(2'd0, 0, d);
    chk("R7 flag still set with enable 0", {15'd0, d[3]}, 16'd1);
    wr(2'd0, 2'b01, 16'h0086, e);
    rd(2'd0, 0, d);
    chk("R5 write 0 clears flag", {15'd0, d[3]}, 16'd0);
    rd(2'd0, 1, d);
    chk("R6 rmw read flag as 1", {14'd0, d[11], d[3]}, 16'd3);
    rd(2'd0, 0, d);
    chk("R6 plain read flag 0", {15'd0, d[3]}, 16'd0);

    wr(2'd0, 2'b01, 16'h0080, e);
    push(e, 2, 0, 0, "R3 oe cleared");
    drain();
    wr(2'd0, 2'b11, 16'hC0C0, e);
    rd(2'd0, 0, d);
    chk("R12 undefined bit reads 0", d, 16'h8080);

    // R8 mode 10
    wr(2'd1, 2'b01, 16'h0000, e);
    wr(2'd2, 2'b01, 16'h0005, e);
    wr(2'd0, 2'b11, 16'hA083, e);
    push(e+1, 0, 0, 0, "R8 low after load");
    push(e+2, 0, 0, 1, "R8 runs alone as independent");
    drain();
    rd(2'd0, 0, d);
    chk("R8 illegal mode status", {15'd0, d[4]}, 16'd1);
    wr(2'd0, 2'b11, 16'h8080, e);

    // R9 single run in mode 01
    wr(2'd0, 2'b11, 16'h9083, e);
    push(e+2, 0, 0, 0, "R9 channel 0 held");
    push(e+4, 0, 0, 0, "R9 channel 0 still held");
    drain();
    rd(2'd0, 0, d);
    chk("R9 pair error status", {15'd0, d[5]}, 16'd1);

    // R11 prescaled
    wr(2'd1, 2'b11, 16'h0101, e);
    wr(2'd2, 2'b11, 16'h0101, e);
    wr(2'd0, 2'b11, 16'h9383, e);
    push(e+3, 0, 0, 1, "R11 channel 0 high");
    push(e+4, 0, 1, 0, "R11 channel 1 low");
    push(e+5, 0, 1, 1, "R11 channel 1 high after two prescale ticks");
    push(e+8, 0, 1, 1, "R11 channel 1 holds high");
    push(e+9, 0, 1, 0, "R11 channel 1 low again");
    drain();
    rd(2'd0, 0, d);
    chk("R9 pair error clears", {15'd0, d[5]}, 16'd0);
    wr(2'd0, 2'b11, 16'h8080, e);

    // R10 chained
    wr(2'd1, 2'b11, 16'h0102, e);
    wr(2'd2, 2'b11, 16'h0003, e);
    wr(2'd0, 2'b11, 16'hB787, e);
    push(e+4, 1, 1, 0, "R10 no flag at lower byte wrap");
    push(e+259, 1, 1, 0, "R10 no irq before 16-bit underflow");
    push(e+259, 0, 1, 0, "R10 low phase 16-bit");
    push(e+260, 1, 1, 1, "R10 irq at 16-bit underflow");
    push(e+260, 0, 1, 1, "R10 high phase starts");
    push(e+262, 0, 0, 0, "R10 channel 0 output quiet");
    push(e+262, 1, 0, 0, "R10 channel 0 flag not set");
    push(e+263, 0, 1, 1, "R10 high phase end");
    push(e+264, 0, 1, 0, "R10 low again");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule